// File: doc/BRIEF.md
# Process-Tagged Translation Buffer with Clock Replacement

This block is a small, fully associative cache of page table entries. A lookup presents a 32-bit virtual address, the identifier of the running process and an access type (read, write or execute). It is answered in the same cycle with a physical address, a miss or a protection fault. Every entry carries its owning process identifier in its tag, so entries from several processes live side by side and a context switch needs no flush. Pages are 4 KB: the upper 20 address bits form the virtual page number and the low 12 bits pass through as the page offset.

A miss is left to an external page table walker, and so is a write to a page whose stored dirty flag is clear. The walker answers with a refill on a valid/ready channel. A refill for a key that is already present overwrites that slot in place. Otherwise the refill takes the lowest-numbered empty slot. When every slot is valid, a clock hand sweeps the per-entry use bits to pick the victim, which approximates least-recently-used order. The lookup side has no ready: the buffer accepts every request it is shown and answers it combinationally. On the refill side, `fill_ready` is low only while `flush` is high. While `fill_ready` is low, the walker must hold `fill_valid` and the refill fields steady. A refill counts as taken on a clock edge where both `fill_valid` and `fill_ready` are high.

Top module: `pid_tlb`

## Requirements
- R1: After reset every slot is invalid, so any lookup reports a miss, and `fill_ready` is high.
- R2: A lookup whose process identifier and page number match a valid slot, and whose access is permitted and not a write to a clean page, raises `rsp_hit` in the same cycle with `rsp_pa` = {stored frame number, va[11:0]}.
- R3: A slot matches only when both its process identifier and its page number equal the request's. The same page number under another process identifier misses.
- R4: `req_acc` is coded 0 read, 1 write, 2 execute, and 3 is never allowed. `fill_perm` bit 0 grants read, bit 1 write and bit 2 execute. A matching lookup whose type is not granted raises only `rsp_fault`. When `req_valid` is high, exactly one of hit, miss and fault is raised.
- R5: A permitted write that matches a slot whose dirty flag is clear raises `rsp_miss`. A refill whose key is already present rewrites that same slot, with its new permission and dirty bits, and allocates no second slot.
- R6: A refill of a new key, while some slot is invalid, is written into the lowest-numbered invalid slot.
- R7: When all slots are valid, a refill of a new key scans from the hand position upward, wrapping around. It clears each set use bit it passes and replaces the first slot whose use bit is clear; if every bit was set, the slot at the hand is replaced. The hand then moves to the slot after the victim. The hand does not move on any other refill.
- R8: A hit sets the use bit of the slot it hit at the next edge. If a replacement sweep would clear that same bit in that cycle, the hit wins.
- R9: `flush` invalidates every slot at the next edge. While `flush` is high, `fill_ready` is low and no refill is taken.
- R10: Every refill that is taken leaves its slot valid with its use bit set.
- R11: While `req_valid` is low, `rsp_hit`, `rsp_miss` and `rsp_fault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all slots |
| req_valid | input | 1 | Lookup present this cycle |
| req_va | input | 32 | Virtual address |
| req_pid | input | 8 | Process identifier of the lookup |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| rsp_hit | output | 1 | Translation valid this cycle |
| rsp_miss | output | 1 | Walker must service this lookup |
| rsp_fault | output | 1 | Access type not permitted |
| rsp_pa | output | 32 | Physical address on a hit, zero otherwise |
| fill_valid | input | 1 | Walker offers a refill |
| fill_ready | output | 1 | Refill accepted this cycle |
| fill_pid | input | 8 | Process identifier of the refill |
| fill_vpn | input | 20 | Virtual page number of the refill |
| fill_ppn | input | 20 | Physical frame number of the refill |
| fill_perm | input | 3 | Permission bits {execute, write, read} |
| fill_dirty | input | 1 | Dirty flag of the refill |

## Verification
Two functions can land in one cycle: a lookup hit marking its slot as used, and a refill sweep clearing use bits. The bench provokes this directly. It first fills every slot and touches each one so that every use bit is set. It then hits one slot in the same cycle as a refill, so the sweep clears that slot's bit while the hit sets it. Two later refills must then skip the slot that was hit and evict its neighbour instead, which is judged purely by which lookups still hit. Random traffic then repeats such collisions, along with flush-versus-refill cycles, against a bench-side model of the slots, use bits and hand.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
  localparam int PERM_W_BITS = 3;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int PID_W   = 8,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][PID_W-1:0] pid_tab,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_tab,
  input  logic [PID_W-1:0]              key_pid,
  input  logic [VPN_W-1:0]              key_vpn,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = valid[g] && (pid_tab[g] == key_pid) && (vpn_tab[g] == key_vpn);
  end

  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] used,
  input  logic [IDX_W-1:0]   hand,
  output logic               inv_any,
  output logic [IDX_W-1:0]   inv_idx,
  output logic [IDX_W-1:0]   sweep_idx,
  output logic [ENTRIES-1:0] sweep_clr,
  output logic [IDX_W-1:0]   hand_next
);
  always_comb begin
    inv_any = 1'b0;
    inv_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        inv_any = 1'b1;
        inv_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin : sweep
    logic found;
    int   pos;
    found     = 1'b0;
    sweep_idx = hand;
    sweep_clr = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      pos = int'(hand) + k;
      if (pos >= ENTRIES) pos = pos - ENTRIES;
      if (!found) begin
        if (!used[pos]) begin
          found     = 1'b1;
          sweep_idx = IDX_W'(pos);
        end else begin
          sweep_clr[pos] = 1'b1;
        end
      end
    end
    hand_next = (int'(sweep_idx) == ENTRIES - 1) ? '0 : sweep_idx + 1'b1;
  end
endmodule

// File: rtl/pid_tlb.sv
module pid_tlb #(
  parameter int ENTRIES   = 8,
  parameter int PID_W     = 8,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_va,
  input  logic [PID_W-1:0]        req_pid,
  input  logic [1:0]              req_acc,
  output logic                    rsp_hit,
  output logic                    rsp_miss,
  output logic                    rsp_fault,
  output logic [PPN_W+PAGE_BITS-1:0] rsp_pa,
  input  logic                    fill_valid,
  output logic                    fill_ready,
  input  logic [PID_W-1:0]        fill_pid,
  input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
  input  logic [PPN_W-1:0]        fill_ppn,
  input  logic [2:0]              fill_perm,
  input  logic                    fill_dirty
);
  import tlb_pkg::*;

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]                  valid_q, used_q, dirty_q;
  logic [ENTRIES-1:0][PID_W-1:0]       pid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]       vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]       ppn_q;
  logic [ENTRIES-1:0][PERM_W_BITS-1:0] perm_q;
  logic [IDX_W-1:0]                    hand_q;

  logic [VPN_W-1:0] lk_vpn;
  logic             lk_match, lk_allowed, lk_clean_wr;
  logic [IDX_W-1:0] lk_idx;
  logic [PERM_W_BITS-1:0] lk_perm;

  logic             fm_hit, inv_any, fill_go, do_sweep;
  logic [IDX_W-1:0] fm_idx, inv_idx, sweep_idx, hand_next, target;
  logic [ENTRIES-1:0] sweep_clr, used_n;

  assign lk_vpn = req_va[VA_W-1:PAGE_BITS];

  tlb_match #(.ENTRIES(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_look (
    .valid(valid_q), .pid_tab(pid_q), .vpn_tab(vpn_q),
    .key_pid(req_pid), .key_vpn(lk_vpn), .hit(lk_match), .idx(lk_idx)
  );

  tlb_match #(.ENTRIES(ENTRIES), .PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_fmatch (
    .valid(valid_q), .pid_tab(pid_q), .vpn_tab(vpn_q),
    .key_pid(fill_pid), .key_vpn(fill_vpn), .hit(fm_hit), .idx(fm_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid(valid_q), .used(used_q), .hand(hand_q),
    .inv_any(inv_any), .inv_idx(inv_idx),
    .sweep_idx(sweep_idx), .sweep_clr(sweep_clr), .hand_next(hand_next)
  );

  // Lookup: permission and clean-page write detection
  assign lk_perm = perm_q[lk_idx];
  always_comb begin
    case (req_acc)
      ACC_READ:  lk_allowed = lk_perm[PERM_R];
      ACC_WRITE: lk_allowed = lk_perm[PERM_W];
      ACC_EXEC:  lk_allowed = lk_perm[PERM_X];
      default:   lk_allowed = 1'b0;
    endcase
  end
  assign lk_clean_wr = (req_acc == ACC_WRITE) && !dirty_q[lk_idx];

  assign rsp_fault = req_valid && lk_match && !lk_allowed;
  assign rsp_hit   = req_valid && lk_match && lk_allowed && !lk_clean_wr;
  assign rsp_miss  = req_valid && (!lk_match || (lk_allowed && lk_clean_wr));
  assign rsp_pa    = rsp_hit ? {ppn_q[lk_idx], req_va[PAGE_BITS-1:0]} : '0;

  // Refill slot choice: in place, then empty slot, then clock sweep
  assign fill_ready = !flush;
  assign fill_go    = fill_valid && fill_ready;
  assign do_sweep   = fill_go && !fm_hit && !inv_any;
  assign target     = fm_hit ? fm_idx : (inv_any ? inv_idx : sweep_idx);

  always_comb begin
    used_n = used_q;
    if (do_sweep) used_n = used_n & ~sweep_clr;
    if (rsp_hit)  used_n[lk_idx] = 1'b1;
    if (fill_go)  used_n[target] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      used_q  <= '0;
      dirty_q <= '0;
      hand_q  <= '0;
      pid_q   <= '0;
      vpn_q   <= '0;
      ppn_q   <= '0;
      perm_q  <= '0;
    end else begin
      used_q <= used_n;
      if (do_sweep) hand_q <= hand_next;
      if (flush) begin
        valid_q <= '0;
      end else if (fill_go) begin
        valid_q[target] <= 1'b1;
        pid_q[target]   <= fill_pid;
        vpn_q[target]   <= fill_vpn;
        ppn_q[target]   <= fill_ppn;
        perm_q[target]  <= fill_perm;
        dirty_q[target] <= fill_dirty;
      end
    end
  end
endmodule

// File: rtl/pid_tlb_chk.sv
module pid_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               req_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_fault,
  input logic               fill_valid,
  input logic               fill_ready,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] used_q,
  input logic [IDX_W-1:0]   lk_idx
);
  logic [IDX_W-1:0] last_idx;
  always_ff @(posedge clk) last_idx <= lk_idx;

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  // R4
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0);

  // R9
  flush_blocks_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fill_ready);

  // R8
  hit_marks_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |=> used_q[last_idx]);

  // R10
  fill_installs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> (valid_q != '0) && (used_q != '0));
endmodule

bind pid_tlb pid_tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
  .fill_valid(fill_valid), .fill_ready(fill_ready),
  .valid_q(valid_q), .used_q(used_q), .lk_idx(lk_idx)
);

// File: tb/pid_tlb_bench.sv
module pid_tlb_bench;
  localparam int E = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [7:0]  req_pid = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_hit, rsp_miss, rsp_fault, fill_ready;
  logic [31:0] rsp_pa;
  logic        fill_valid = 1'b0;
  logic [7:0]  fill_pid = '0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic [2:0]  fill_perm = '0;
  logic        fill_dirty = 1'b0;

  int checks = 0;
  int errors = 0;

  // model state
  bit        m_valid[E], m_used[E], m_dirty[E];
  bit [2:0]  m_perm[E];
  bit [7:0]  m_pid[E];
  bit [19:0] m_vpn[E], m_ppn[E];
  int        m_hand;

  always #10 clk = ~clk;

  pid_tlb u_pid_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_va(req_va), .req_pid(req_pid), .req_acc(req_acc),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_pid(fill_pid),
    .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm), .fill_dirty(fill_dirty)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int find(input bit [7:0] pid, input bit [19:0] vpn);
    for (int i = 0; i < E; i++)
      if (m_valid[i] && m_pid[i] == pid && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  // expected outcome code: 0 none, 1 hit, 2 miss, 3 fault, 4 clean-write miss
  function automatic int outcome(input bit rv, input bit [31:0] va, input bit [7:0] pid,
                                 input bit [1:0] acc, output int idx);
    bit ok;
    idx = find(pid, va[31:12]);
    if (!rv) return 0;
    if (idx < 0) return 2;
    ok = (acc == 2'd0) ? m_perm[idx][0] : (acc == 2'd1) ? m_perm[idx][1] :
         (acc == 2'd2) ? m_perm[idx][2] : 1'b0;
    if (!ok) return 3;
    if (acc == 2'd1 && !m_dirty[idx]) return 4;
    return 1;
  endfunction

  task automatic step(input bit fl, input bit rv, input bit [31:0] va, input bit [7:0] pid,
                      input bit [1:0] acc, input bit fv, input bit [7:0] fpid,
                      input bit [19:0] fvpn, input bit [19:0] fppn, input bit [2:0] fperm,
                      input bit fdirty);
    int idx, kind, t;
    bit found;
    string tag;
    @(negedge clk);
    flush = fl; req_valid = rv; req_va = va; req_pid = pid; req_acc = acc;
    fill_valid = fv; fill_pid = fpid; fill_vpn = fvpn; fill_ppn = fppn;
    fill_perm = fperm; fill_dirty = fdirty;
    #2;
    kind = outcome(rv, va, pid, acc, idx);
    case (kind)
      0: tag = "R11";
      1: tag = "R2";
      2: tag = "R3";
      3: tag = "R4";
      default: tag = "R5";
    endcase
    chk({rsp_hit, rsp_miss, rsp_fault} ==
        {kind == 1, kind == 2 || kind == 4, kind == 3}, tag,
        {rsp_hit, rsp_miss, rsp_fault},
        {kind == 1, kind == 2 || kind == 4, kind == 3});
    if (kind == 1)
      chk(rsp_pa == {m_ppn[idx], va[11:0]}, "R2", rsp_pa, {m_ppn[idx], va[11:0]});
    chk(fill_ready == !fl, "R9", fill_ready, !fl);
    @(posedge clk);
    // model update
    t = -1;
    if (!fl && fv) begin
      t = find(fpid, fvpn);
      if (t < 0)
        for (int i = E - 1; i >= 0; i--) if (!m_valid[i]) t = i;
      if (t < 0) begin
        found = 0;
        for (int k = 0; k < E; k++) begin
          int p = (m_hand + k) % E;
          if (!found) begin
            if (!m_used[p]) begin found = 1; t = p; end
            else m_used[p] = 0;
          end
        end
        if (!found) t = m_hand;
        m_hand = (t + 1) % E;
      end
    end
    if (kind == 1) m_used[idx] = 1;
    if (fl) begin
      for (int i = 0; i < E; i++) m_valid[i] = 0;
    end else if (t >= 0) begin
      m_valid[t] = 1; m_used[t] = 1; m_pid[t] = fpid; m_vpn[t] = fvpn;
      m_ppn[t] = fppn; m_perm[t] = fperm; m_dirty[t] = fdirty;
    end
  endtask

  task automatic look(input bit [7:0] pid, input bit [19:0] vpn, input bit [1:0] acc);
    step(0, 1, {vpn, 12'h5a4}, pid, acc, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input bit [7:0] pid, input bit [19:0] vpn, input bit [19:0] ppn,
                      input bit [2:0] perm, input bit dirty);
    step(0, 0, 0, 0, 0, 1, pid, vpn, ppn, perm, dirty);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < E; i++) begin
      m_valid[i] = 0; m_used[i] = 0; m_dirty[i] = 0; m_perm[i] = 0;
      m_pid[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
    end
    m_hand = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look(8'h01, 20'h00010, 2'd0);
    // R11: idle request
    step(0, 0, 32'h00010000, 8'h01, 2'd0, 0, 0, 0, 0, 0, 0);

    // R6: fill all slots in index order
    for (int i = 0; i < E; i++) fill(8'h01, 20'h00100 + 20'(i), 20'h0A000 + 20'(i), 3'b011, 1'b1);
    for (int i = 0; i < E; i++) look(8'h01, 20'h00100 + 20'(i), 2'd0);
    // R3: same page, other process
    look(8'h02, 20'h00101, 2'd0);
    // R4: execute not granted, code 3 never allowed
    look(8'h01, 20'h00102, 2'd2);
    look(8'h01, 20'h00102, 2'd3);

    // R7: all used set, hand 0 -> slot 0 replaced, hand 1
    fill(8'h03, 20'h00200, 20'h0B000, 3'b111, 1'b0);
    look(8'h01, 20'h00100, 2'd0);
    look(8'h03, 20'h00200, 2'd0);
    // R5: clean write misses, in-place refill with dirty set
    look(8'h03, 20'h00200, 2'd1);
    fill(8'h03, 20'h00200, 20'h0B001, 3'b111, 1'b1);
    look(8'h03, 20'h00200, 2'd1);
    for (int i = 1; i < E; i++) look(8'h01, 20'h00100 + 20'(i), 2'd0);

    // R8: hit and sweep on the same slot in one cycle
    step(0, 1, {20'h00103, 12'h010}, 8'h01, 2'd0, 1, 8'h04, 20'h00300, 20'h0C000, 3'b001, 1'b0);
    fill(8'h04, 20'h00301, 20'h0C001, 3'b001, 1'b0);
    fill(8'h04, 20'h00302, 20'h0C002, 3'b001, 1'b0);
    for (int i = 1; i < E; i++) look(8'h01, 20'h00100 + 20'(i), 2'd0);

    // R9: flush with a refill offered in the same cycle
    step(1, 1, {20'h00103, 12'h0}, 8'h01, 2'd0, 1, 8'h05, 20'h00400, 20'h0D000, 3'b111, 1'b1);
    look(8'h01, 20'h00103, 2'd0);
    look(8'h05, 20'h00400, 2'd0);
    // R10: refill after flush installs and hits
    fill(8'h05, 20'h00400, 20'h0D000, 3'b111, 1'b1);
    look(8'h05, 20'h00400, 2'd1);

    // random traffic
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      bit [31:0] r = $urandom;
      step(r[6:0] == 0, r[7], {16'h0, r[11:8], r[19:8]}, {6'h0, r[13:12]}, r[15:14],
           r[17] & r[16], {6'h0, r[21:20]}, {16'h0, r[25:22]}, 20'($urandom),
           r[28:26], r[29]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule